// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block sits on the receive path and decides, from the 48-bit destination address at the head of a frame, whether the frame is accepted. The address arrives one byte per valid cycle, in transmission order. A start strobe comes with the first byte. One cycle after the last address byte, the block shows a one-cycle decision pulse with an accept flag.

A frame is accepted under any of four conditions:
- promiscuous mode is on;
- the address is the broadcast address;
- the address equals the programmed station address;
- the address is a group address and its hash selects a set bit in a 64-bit table.

The hash is a reflected CRC-32 over the six address bytes. The top six bits of the CRC pick one table bit. The table is split across two 32-bit registers. Setting every table bit gives all-multicast behaviour. Software loads the station address, the table and the control bit through a simple write port.

A controller steps through three states:
- `S_IDLE` waits for a start. Its transition START moves to `S_COLLECT`.
- `S_COLLECT` counts bytes. RESTART is a new start that reloads the count and stays. LAST_BYTE moves to `S_DECIDE` on the sixth byte.
- `S_DECIDE` presents the decision for one cycle. From there, RETIRE returns to `S_IDLE`, or a start moves straight to `S_COLLECT`.

Top module: `mcast_hash_filter`

## Requirements
- R1: Reset zeroes both hash-table registers, the station address and the control register, and holds `decision_valid` and `decision_accept` low. Right after reset, a group address is rejected.
- R2: `decision_valid` is high for exactly the one cycle after the edge that samples the sixth address byte. `decision_accept` is low whenever `decision_valid` is low.
- R3: When control bit 0 (write address 4) is set, every address is accepted.
- R4: The broadcast address FF:FF:FF:FF:FF:FF is accepted with an empty table and no station match.
- R5: An address equal to the station address is accepted. Write address 0 holds bytes 0..3, with byte 0 in bits 31:24 and byte 3 in bits 7:0. Write address 1 holds byte 4 in bits 31:24 and byte 5 in bits 23:16.
- R6: For a group address (bit 0 of byte 0 set), the CRC is computed as follows:
  - the polynomial is reflected 0xEDB88320 and the register starts at all ones;
  - the six bytes are processed in arrival order, each least significant bit first;
  - there is no final inversion;
  - the index is CRC bits 31:26.
  An index of 32..63 tests bit (index-32) of the high table register (write address 3). An index of 0..31 tests that bit of the low table register (write address 2). The address is accepted exactly when that bit is set.
- R7: An individual address (bit 0 of byte 0 clear) that is not the station address is rejected when promiscuous mode is off, even if every table bit is set.
- R8: With both table registers written to all ones, every group address is accepted.
- R9: A start strobe while bytes are being collected discards the partial address and begins a new one. Bytes presented without a preceding start produce no decision.
- R10: Cycles with `da_valid` low between address bytes pause collection without changing the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select: 0 station low, 1 station high, 2 table low, 3 table high, 4 control |
| cfg_wdata | input | 32 | Register write data |
| da_valid | input | 1 | Address byte present on `da_byte` |
| da_start | input | 1 | Marks the first byte of an address (qualified by `da_valid`) |
| da_byte | input | 8 | Destination address byte, transmission order |
| decision_valid | output | 1 | One-cycle pulse carrying the decision |
| decision_accept | output | 1 | Accept flag, meaningful with `decision_valid` |

## Verification
Each kind of internal fault shows up differently at the ports:
- **CRC fault.** A wrong CRC register or a wrong bit order selects the wrong table bit. It is exposed only when a single table bit is set: a programmed group address is rejected, or a neighbour is wrongly accepted, on that frame's decision pulse. Hash indices from both halves of the table are therefore driven.
- **Byte-count fault.** A counter or state fault moves the decision pulse off the cycle right after the sixth byte, or makes it vanish or repeat. The pulse is timed to the exact cycle.
- **Address-storage fault.** A wrong byte lane in the station compare or in the stored address makes the exact-match and broadcast decisions fail on the first such frame.

// File: rtl/mcaf_pkg.sv
package mcaf_pkg;

    localparam int          ADDR_BYTES = 6;
    localparam int          HASH_BITS  = 6;
    localparam int          REG_W      = 32;
    localparam int          CFG_AW     = 3;
    localparam logic [31:0] CRC_POLY   = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED   = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_COLLECT = 2'd1,
        S_DECIDE  = 2'd2
    } fstate_e;

    typedef enum logic [CFG_AW-1:0] {
        RA_STA_LO  = 3'd0,
        RA_STA_HI  = 3'd1,
        RA_HASH_LO = 3'd2,
        RA_HASH_HI = 3'd3,
        RA_CTRL    = 3'd4
    } reg_addr_e;

    // One byte through the reflected CRC, least significant data bit first.
    function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/mcaf_cfg_regs.sv
module mcaf_cfg_regs
    import mcaf_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int AW = CFG_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] waddr,
    input  logic [RW-1:0] wdata,
    output logic [RW-1:0] sta_lo,
    output logic [15:0]   sta_hi,
    output logic [RW-1:0] hash_lo,
    output logic [RW-1:0] hash_hi,
    output logic          promisc
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sta_lo  <= '0;
            sta_hi  <= '0;
            hash_lo <= '0;
            hash_hi <= '0;
            promisc <= 1'b0;
        end else if (wr_en) begin
            case (reg_addr_e'(waddr))
                RA_STA_LO:  sta_lo  <= wdata;
                RA_STA_HI:  sta_hi  <= wdata[RW-1 -: 16];
                RA_HASH_LO: hash_lo <= wdata;
                RA_HASH_HI: hash_hi <= wdata;
                RA_CTRL:    promisc <= wdata[0];
                default:    ;
            endcase
        end
    end

    // R1: the table is empty on the first cycle out of reset
    p_table_clear_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (hash_lo == '0 && hash_hi == '0 && !promisc));

endmodule

// File: rtl/mcaf_ctrl.sv
module mcaf_ctrl
    import mcaf_pkg::*;
#(
    parameter int N_BYTES = ADDR_BYTES
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   da_valid,
    input  logic                   da_start,
    input  logic [7:0]             da_byte,
    output logic [8*N_BYTES-1:0]   addr_flat,
    output logic                   take_byte,
    output logic                   first_byte,
    output logic                   decide
);

    localparam int          CW   = $clog2(N_BYTES + 1);
    localparam logic [CW-1:0] LAST = CW'(N_BYTES - 1);

    fstate_e       state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] widx;

    // next-state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            S_IDLE: begin
                if (da_valid && da_start) begin
                    cnt_d   = CW'(1);
                    state_d = (N_BYTES == 1) ? S_DECIDE : S_COLLECT;
                end
            end
            S_COLLECT: begin
                if (da_valid && da_start) begin
                    cnt_d = CW'(1);
                end else if (da_valid) begin
                    cnt_d = cnt_q + CW'(1);
                    if (cnt_q == LAST) state_d = S_DECIDE;
                end
            end
            S_DECIDE: begin
                if (da_valid && da_start) begin
                    cnt_d   = CW'(1);
                    state_d = S_COLLECT;
                end else begin
                    state_d = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        first_byte = da_valid && da_start;
        take_byte  = first_byte || (state_q == S_COLLECT && da_valid);
        decide     = (state_q == S_DECIDE);
        widx       = first_byte ? '0 : cnt_q;
    end

    for (genvar g = 0; g < N_BYTES; g++) begin : g_byte
        logic [7:0] b_q;
        always_ff @(posedge clk) begin
            if (!rst_n)                              b_q <= '0;
            else if (take_byte && widx == CW'(g))    b_q <= da_byte;
        end
        assign addr_flat[8*g +: 8] = b_q;
    end

    // R2: the decision follows the final byte by one cycle
    p_decide_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_COLLECT && da_valid && !da_start && cnt_q == LAST) |=> decide);

    // R2: the decision never lasts two cycles
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        decide |=> !decide);

    // R9: no decision grows out of idle without a start
    p_no_orphan_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !(da_valid && da_start)) |=> !decide);

endmodule

// File: rtl/mcaf_crc_acc.sv
module mcaf_crc_acc
    import mcaf_pkg::*;
#(
    parameter int HB = HASH_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          first,
    input  logic [7:0]    din,
    output logic [HB-1:0] hash_idx
);

    logic [31:0] crc_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    crc_q <= CRC_SEED;
        else if (take) crc_q <= crc_byte(first ? CRC_SEED : crc_q, din);
    end

    assign hash_idx = crc_q[31 -: HB];

endmodule

// File: rtl/mcaf_match.sv
module mcaf_match
    import mcaf_pkg::*;
#(
    parameter int N_BYTES = ADDR_BYTES,
    parameter int RW      = REG_W,
    parameter int HB      = HASH_BITS
) (
    input  logic [8*N_BYTES-1:0] addr_flat,
    input  logic [HB-1:0]        hash_idx,
    input  logic [RW-1:0]        sta_lo,
    input  logic [15:0]          sta_hi,
    input  logic [RW-1:0]        hash_lo,
    input  logic [RW-1:0]        hash_hi,
    input  logic                 promisc,
    output logic                 accept
);

    logic [8*N_BYTES-1:0] sta_flat;
    logic [HB-2:0]        bit_pos;
    logic                 table_hit;
    logic                 is_bcast;
    logic                 is_group;
    logic                 is_own;

    // byte 0 in the low lane of the flat vector
    assign sta_flat = {sta_hi[7:0], sta_hi[15:8],
                       sta_lo[7:0], sta_lo[15:8], sta_lo[23:16], sta_lo[31:24]};

    assign bit_pos   = hash_idx[HB-2:0];
    assign table_hit = hash_idx[HB-1] ? hash_hi[bit_pos] : hash_lo[bit_pos];
    assign is_bcast  = &addr_flat;
    assign is_group  = addr_flat[0];
    assign is_own    = (addr_flat == sta_flat);

    assign accept = promisc | is_bcast | is_own | (is_group & table_hit);

endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
    import mcaf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr_en,
    input  logic [2:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    input  logic        da_valid,
    input  logic        da_start,
    input  logic [7:0]  da_byte,
    output logic        decision_valid,
    output logic        decision_accept
);

    localparam int AB = 8 * ADDR_BYTES;

    logic [REG_W-1:0]     sta_lo, hash_lo, hash_hi;
    logic [15:0]          sta_hi;
    logic                 promisc;
    logic [AB-1:0]        addr_flat;
    logic                 take_byte, first_byte, decide;
    logic [HASH_BITS-1:0] hash_idx;
    logic                 accept;

    mcaf_cfg_regs #(.RW(REG_W), .AW(CFG_AW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .waddr(cfg_addr), .wdata(cfg_wdata),
        .sta_lo(sta_lo), .sta_hi(sta_hi), .hash_lo(hash_lo), .hash_hi(hash_hi), .promisc(promisc)
    );

    mcaf_ctrl #(.N_BYTES(ADDR_BYTES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da_start(da_start), .da_byte(da_byte),
        .addr_flat(addr_flat), .take_byte(take_byte), .first_byte(first_byte), .decide(decide)
    );

    mcaf_crc_acc #(.HB(HASH_BITS)) u_crc (
        .clk(clk), .rst_n(rst_n), .take(take_byte), .first(first_byte), .din(da_byte),
        .hash_idx(hash_idx)
    );

    mcaf_match #(.N_BYTES(ADDR_BYTES), .RW(REG_W), .HB(HASH_BITS)) u_match (
        .addr_flat(addr_flat), .hash_idx(hash_idx), .sta_lo(sta_lo), .sta_hi(sta_hi),
        .hash_lo(hash_lo), .hash_hi(hash_hi), .promisc(promisc), .accept(accept)
    );

    assign decision_valid  = decide;
    assign decision_accept = decide & accept;

    // R3: promiscuous mode accepts everything
    p_promisc_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (decision_valid && promisc) |-> decision_accept);

    // R4: broadcast always passes
    p_bcast_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (decision_valid && (&addr_flat)) |-> decision_accept);

    // R6: an empty table passes no non-broadcast group address unless it is the station
    p_empty_table_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (decision_valid && !promisc && hash_lo == '0 && hash_hi == '0 &&
         addr_flat[0] && !(&addr_flat) && !sta_lo[24]) |-> !decision_accept);

    // R2: no accept without a decision
    p_accept_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !decision_valid |-> !decision_accept);

endmodule

// File: tb/mcast_hash_filter_tb_top.sv
module mcast_hash_filter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr_en;
    logic [2:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic        da_valid, da_start;
    logic [7:0]  da_byte;
    logic        decision_valid, decision_accept;

    always #5 clk = ~clk;

    mcast_hash_filter dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .da_valid(da_valid), .da_start(da_start), .da_byte(da_byte),
        .decision_valid(decision_valid), .decision_accept(decision_accept)
    );

    int checks = 0;
    int failures = 0;
    int n_dec = 0;
    bit done = 0;
    bit    exp_q[$];
    string req_q[$];

    logic [47:0] sh_sta;
    logic [31:0] sh_hlo, sh_hhi;
    bit          sh_prom;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int hidx(input logic [47:0] a);
        logic [31:0] c;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < 6; i++) begin
            logic [7:0] b;
            b = a[47 - 8*i -: 8];
            for (int k = 0; k < 8; k++) begin
                logic fb;
                fb = c[0] ^ b[k];
                c  = c >> 1;
                if (fb) c = c ^ 32'hEDB88320;
            end
        end
        return int'(c[31:26]);
    endfunction

    function automatic bit model(input logic [47:0] a);
        int  ix;
        bit  hit;
        ix  = hidx(a);
        hit = (ix >= 32) ? sh_hhi[ix-32] : sh_hlo[ix];
        return sh_prom || (&a) || (a == sh_sta) || (a[40] && hit);
    endfunction

    task automatic wr_reg(input logic [2:0] ad, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = ad; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        case (ad)
            3'd0: sh_sta[47:16] = d;
            3'd1: sh_sta[15:0]  = d[31:16];
            3'd2: sh_hlo = d;
            3'd3: sh_hhi = d;
            3'd4: sh_prom = d[0];
            default: ;
        endcase
    endtask

    task automatic send_addr(input logic [47:0] a, input int gap, input bit tmg, input string req);
        exp_q.push_back(model(a));
        req_q.push_back(req);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            da_valid = 1'b1; da_start = (i == 0); da_byte = a[47 - 8*i -: 8];
            if (i < 5) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    da_valid = 1'b0; da_start = 1'b0;
                end
            end
        end
        @(negedge clk);
        da_valid = 1'b0; da_start = 1'b0;
        if (tmg) chk(decision_valid == 1'b1, "R2 pulse after sixth byte", 32'(decision_valid), 1);
        @(negedge clk);
        if (tmg) chk(decision_valid == 1'b0, "R2 pulse one cycle", 32'(decision_valid), 0);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n === 1'b1 && decision_valid === 1'b1) begin
            n_dec++;
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R9 unexpected decision actual=1 expected=0");
            end else begin
                bit    e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                chk(decision_accept == e, r, 32'(decision_accept), 32'(e));
            end
        end
    end

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=1 expected=0");
            finish_run();
        end
    end

    initial begin
        logic [47:0] alo, ahi, a;
        int ilo, ihi, n0;
        bit flo, fhi;
        rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        da_valid = 1'b0; da_start = 1'b0; da_byte = '0;
        sh_sta = '0; sh_hlo = '0; sh_hhi = '0; sh_prom = 1'b0;
        repeat (3) @(negedge clk);
        chk(decision_valid == 1'b0 && decision_accept == 1'b0, "R1 outputs in reset",
            {30'd0, decision_valid, decision_accept}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: empty table rejects a group address
        send_addr(48'h01005E000001, 0, 1'b1, "R1 group rejected after reset");
        send_addr(48'h020000000007, 0, 1'b0, "R1 individual rejected after reset");
        // R4
        send_addr(48'hFFFFFFFFFFFF, 0, 1'b0, "R4 broadcast");
        // R5
        wr_reg(3'd0, 32'h00112233);
        wr_reg(3'd1, 32'h44550000);
        send_addr(48'h001122334455, 0, 1'b0, "R5 station match");
        send_addr(48'h001122334454, 0, 1'b0, "R7 near-station rejected");

        // find one address per table half
        flo = 0; fhi = 0; alo = '0; ahi = '0; ilo = 0; ihi = 0;
        for (int k = 0; k < 256; k++) begin
            a = {40'h01005E0000, 8'(k)};
            if (!flo && hidx(a) < 32)  begin flo = 1; alo = a; ilo = hidx(a); end
            if (!fhi && hidx(a) >= 32) begin fhi = 1; ahi = a; ihi = hidx(a); end
        end
        chk(flo && fhi, "R6 test vectors found", {30'd0, flo, fhi}, 3);

        // R6: low half
        wr_reg(3'd2, 32'h1 << ilo);
        send_addr(alo, 0, 1'b0, "R6 low-register bit accepts");
        send_addr(ahi, 0, 1'b0, "R6 high index with low bit only");
        // R6: high half
        wr_reg(3'd2, 32'h0);
        wr_reg(3'd3, 32'h1 << (ihi - 32));
        send_addr(ahi, 0, 1'b0, "R6 high-register bit accepts");
        send_addr(alo, 0, 1'b0, "R6 low index with high bit only");
        // R6: right bit number, wrong register
        wr_reg(3'd3, 32'h1 << ilo);
        send_addr(alo, 0, 1'b0, "R6 wrong register rejects");

        // R8 and R7 with full table
        wr_reg(3'd2, 32'hFFFFFFFF);
        wr_reg(3'd3, 32'hFFFFFFFF);
        send_addr(48'h333300000001, 0, 1'b0, "R8 all-multicast accepts");
        send_addr(48'h0180C2000000, 0, 1'b0, "R8 all-multicast accepts second");
        send_addr(48'h3C0000000001, 0, 1'b0, "R7 individual rejected with full table");

        // R10: gaps between bytes
        wr_reg(3'd2, 32'h0);
        wr_reg(3'd3, 32'h0);
        send_addr(48'h001122334455, 2, 1'b0, "R10 gapped station match");
        send_addr(alo, 3, 1'b0, "R10 gapped group with empty table");

        // R9: restart mid-address
        @(negedge clk); da_valid = 1; da_start = 1; da_byte = 8'hFF;
        @(negedge clk); da_start = 0; da_byte = 8'hFF;
        @(negedge clk); da_byte = 8'hFF;
        send_addr(48'h020000000009, 0, 1'b1, "R9 restart takes new address");
        // R9: orphan bytes
        n0 = n_dec;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); da_valid = 1; da_start = 0; da_byte = 8'hFF;
        end
        @(negedge clk); da_valid = 0;
        repeat (3) @(negedge clk);
        chk(n_dec == n0, "R9 bytes without start ignored", n_dec, n0);

        // R3
        wr_reg(3'd4, 32'h1);
        send_addr(48'h02AB00CD00EF, 0, 1'b0, "R3 promiscuous individual");
        send_addr(alo, 0, 1'b1, "R3 promiscuous group");
        wr_reg(3'd4, 32'h0);
        send_addr(48'h02AB00CD00EF, 0, 1'b0, "R3 promiscuous cleared");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R2 every address decided", exp_q.size(), 0);
        done = 1;
        finish_run();
    end

endmodule